// File: doc/BRIEF.md
# Slow Memory Read Sequencer

This block is a bus master that reads one word from a memory slower than the core that uses it. The core raises a request with an address. The sequencer puts the address on the memory address bus, then drives an active-low read strobe. It keeps the strobe low for a fixed number of wait cycles so the memory has time to answer. It then returns the strobe high and, in that high cycle, takes the word from the data bus.

The word goes back to the core with a single-cycle valid pulse. A busy output covers the whole transaction, and any request made while busy is dropped. The memory side is a plain parallel bus with one read line and no ready signal. The memory answers only because the sequencer waits long enough.

The wait count is the parameter `WAIT_CYC`, default 1, and it must be at least 1. With the default, a read takes four clock edges from acceptance to the response.

Top module: `msr_read_seq`

## Requirements
- R1: During reset and in the first cycle after it, `mem_rd_n` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: A clock edge that samples `req_valid`=1 while `busy` is 0 accepts the request. In the following cycle `busy` is 1, `mem_addr` equals the sampled `req_addr`, and `mem_rd_n` is still 1.
- R3: `mem_rd_n` falls in the second cycle after acceptance, one cycle after the address was placed. It is never 0 while `busy` is 0.
- R4: `mem_rd_n` stays 0 for exactly 1+`WAIT_CYC` consecutive cycles and then returns to 1 while `busy` is still 1.
- R5: `mem_addr` does not change from the cycle after acceptance until the response cycle.
- R6: The data word is sampled at the clock edge that ends the first cycle with `mem_rd_n` back at 1. `rsp_valid` is 1 for exactly one cycle, 3+`WAIT_CYC` cycles after the acceptance edge, and `rsp_data` then holds the sampled word.
- R7: `busy` is 1 from the cycle after acceptance up to the cycle before the response, and it is 0 in the `rsp_valid` cycle.
- R8: A request made while `busy` is 1 is ignored. The address and the timing of the running transaction do not change, and no new transaction follows it.
- R9: A request made in the `rsp_valid` cycle is accepted, and the next transaction starts with no idle cycle in between.
- R10: `rsp_data` keeps the last captured word until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request from the core |
| req_addr | input | AW | Address of the requested word |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the new word |
| rsp_data | output | DW | Captured word |
| mem_addr | output | AW | Memory address bus |
| mem_rd_n | output | 1 | Read strobe to memory, active low |
| mem_data | input | DW | Memory data bus |

## Verification
Counting the acceptance edge as edge 0, each result has a fixed due time. Busy and the address appear after edge 0, the strobe falls after edge 1, and it rises after edge 2+`WAIT_CYC`. The response and the drop of busy come after edge 3+`WAIT_CYC`. The bench drives and samples on falling edges and steps a cycle index through this window, checking each output against the value due at that index. The memory model puts the correct word on the bus only in the single high-strobe cycle after a full-length low phase and drives a junk value at all other times, so a capture one cycle early or late returns the wrong word.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_WAIT,
        ST_CAPT
    } msr_state_e;

endpackage

// File: rtl/msr_wait_timer.sv
// Down-counter that spaces the low phase of the read strobe.
module msr_wait_timer #(
    parameter int WAIT_CYC = 1,
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAIT_CYC - 1);
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/msr_capture_reg.sv
// Holds the word taken from the memory data bus.
module msr_capture_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] word
);

    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (cap_en) begin
            word_d = bus_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/msr_read_seq.sv
// Read sequencer: address phase, strobe low for 1+WAIT_CYC cycles,
// strobe high with capture, then one-cycle response.
module msr_read_seq
    import msr_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_n,
    input  logic [DW-1:0] mem_data
);

    typedef struct packed {
        msr_state_e    state;
        logic [AW-1:0] addr;
        logic          rd_n;
        logic          valid;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_load, tmr_dec, tmr_done, cap_en;

    msr_wait_timer #(
        .WAIT_CYC(WAIT_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .dec  (tmr_dec),
        .done (tmr_done)
    );

    msr_capture_reg #(
        .DW(DW)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .bus_data(mem_data),
        .word    (rsp_data)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_dec     = 1'b0;
        cap_en      = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.state = ST_ADDR;
                end
            end
            ST_ADDR: begin
                seq_d.rd_n  = 1'b0;
                seq_d.state = ST_STROBE;
            end
            ST_STROBE: begin
                tmr_load    = 1'b1;
                seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                tmr_dec = 1'b1;
                if (tmr_done) begin
                    seq_d.rd_n  = 1'b1;
                    seq_d.state = ST_CAPT;
                end
            end
            ST_CAPT: begin
                cap_en      = 1'b1;
                seq_d.valid = 1'b1;
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.rd_n  = 1'b1;
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, rd_n: 1'b1, valid: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != ST_IDLE);
    assign rsp_valid = seq_q.valid;
    assign mem_addr  = seq_q.addr;
    assign mem_rd_n  = seq_q.rd_n;

endmodule

// File: rtl/msr_read_seq_chk.sv
module msr_read_seq_chk #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int WAIT_CYC = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd_n,
    input logic [DW-1:0] mem_data
);

    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!mem_rd_n) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && mem_rd_n && mem_addr == $past(req_addr)));

    p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> busy);

    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> (low_run == 16'(WAIT_CYC + 1)) && busy);

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    p_rise_then_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |=> rsp_valid);

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_idle_at_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));

endmodule

bind msr_read_seq msr_read_seq_chk #(
    .AW      (AW),
    .DW      (DW),
    .WAIT_CYC(WAIT_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .mem_addr (mem_addr),
    .mem_rd_n (mem_rd_n),
    .mem_data (mem_data)
);

// File: tb/sim_msr_read_seq.sv
`timescale 1ns/1ps
module sim_msr_read_seq;

    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int WAIT = 1;
    localparam logic [DW-1:0] JUNK = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, rsp_valid, mem_rd_n;
    logic [DW-1:0] rsp_data, mem_data;
    logic [AW-1:0] mem_addr;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    msr_read_seq #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
    );

    // Memory model: correct word only in the high-strobe cycle after a full low phase.
    logic       rd_prev = 1'b1;
    logic [7:0] low_cnt = '0;

    always @(posedge clk) begin
        rd_prev <= mem_rd_n;
        if (!mem_rd_n) low_cnt <= rd_prev ? 8'd1 : low_cnt + 8'd1;
    end

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 16'd3) ^ 16'h5A5A;
    endfunction

    assign mem_data = (mem_rd_n && !rd_prev && low_cnt == 8'(WAIT + 1))
                      ? mem_word(mem_addr) : JUNK;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a);
        req_valid = 1'b1;
        req_addr  = a;
    endtask

    // Called at the negedge before the accepting edge; returns at the response negedge.
    task automatic follow(input logic [AW-1:0] a, input bit noise, input logic [AW-1:0] na);
        for (int k = 0; k <= 3 + WAIT; k++) begin
            @(negedge clk);
            if (k == 0 || k == 3 + WAIT) begin
                req_valid = noise && (k == 0);
                if (noise && k == 0) req_addr = na;
            end
            if (k <= 2 + WAIT) begin
                chk(busy == 1'b1, "R7 busy during read", busy, 1);
                chk(mem_addr == a, (k == 0) ? "R2 address placed" : "R5/R8 address stable", mem_addr, a);
                chk(rsp_valid == 1'b0, "R6 no early response", rsp_valid, 0);
            end
            if (k == 0) chk(mem_rd_n == 1'b1, "R2 strobe high at address", mem_rd_n, 1);
            else if (k == 1) chk(mem_rd_n == 1'b0, "R3 strobe falls", mem_rd_n, 0);
            else if (k <= 1 + WAIT) chk(mem_rd_n == 1'b0, "R4 strobe held low", mem_rd_n, 0);
            else chk(mem_rd_n == 1'b1, "R4 strobe released", mem_rd_n, 1);
            if (k == 3 + WAIT) begin
                chk(rsp_valid == 1'b1, "R6 response due", rsp_valid, 1);
                chk(rsp_data == mem_word(a), "R6 captured word", rsp_data, mem_word(a));
                chk(busy == 1'b0, "R7 busy low at response", busy, 0);
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(mem_rd_n == 1'b1, "R1 strobe in reset", mem_rd_n, 1);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(rsp_valid == 1'b0, "R1 valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_rd_n == 1'b1 && busy == 1'b0 && rsp_valid == 1'b0, "R1 idle after reset",
            {mem_rd_n, busy, rsp_valid}, 3'b100);
    endtask

    task automatic t_single(input logic [AW-1:0] a);
        @(negedge clk);
        issue(a);
        follow(a, 1'b0, '0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R6 single-cycle pulse", rsp_valid, 0);
    endtask

    task automatic t_busy_ignore(input logic [AW-1:0] a, input logic [AW-1:0] na);
        @(negedge clk);
        issue(a);
        follow(a, 1'b1, na);
        repeat (2) begin
            @(negedge clk);
            chk(busy == 1'b0 && mem_rd_n == 1'b1, "R8 no extra transaction",
                {busy, mem_rd_n}, 2'b01);
            chk(mem_addr == a, "R8 address untouched", mem_addr, a);
        end
    endtask

    task automatic t_back_to_back(input logic [AW-1:0] a, input logic [AW-1:0] b);
        @(negedge clk);
        issue(a);
        follow(a, 1'b0, '0);
        issue(b);
        follow(b, 1'b0, '0);
        chk(1'b1, "R9 back-to-back", 0, 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && busy == 1'b0, "R9 idle after second", {rsp_valid, busy}, 0);
    endtask

    task automatic t_hold(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        t_single(a);
        w = mem_word(a);
        repeat (5) @(negedge clk);
        chk(rsp_data == w, "R10 word held", rsp_data, w);
        chk(rsp_valid == 1'b0, "R10 no spurious pulse", rsp_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_single(16'h1234);
        t_single(16'h0000);
        t_single(16'hFFFF);
        t_single(16'hA5A5);
        t_busy_ignore(16'h0F0F, 16'h7777);
        t_back_to_back(16'h2468, 16'h1357);
        t_hold(16'h4321);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule